// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt events from two DMA engines and from four user interrupt lines into two sticky status registers, and gates each register with a mask register of the same width. It produces one interrupt request toward the PCIe core. Software reaches the four registers through a small bus with a write strobe and a read strobe.

The block has two modes, chosen by a mode input. In line mode the interrupt output is a level. It stays high while any status bit with its mask bit set is still 1. Software clears a status bit by writing 1 to that bit position. In message mode the block raises a one-cycle request toward the core and waits for the core's acknowledge. On that acknowledge it clears exactly the bits it sent. Bits that arrive while it waits are kept for the next message.

User events are coalesced in message mode. After a message that carried user bits, further user events are recorded but send nothing until the handler writes to the user status register. Each user line may be a one-cycle pulse or a held level. Only its rising edge counts as an event.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `irq_line` is 0 and `msi_req` is 0.
- R2: A high `dma_evt[i]` at a clock edge sets bit i of the DMA status register. The register reads at address 0. The bit order is: bit 0 engine 0 to-host done, bit 1 engine 0 from-host done, bit 2 engine 1 to-host done, bit 3 engine 1 from-host done, bit 4 engine 0 idle, bit 5 engine 1 idle.
- R3: In line mode a status bit stays 1 until software writes 1 to that bit position. Writing 0 leaves the bit unchanged. An event in the same cycle as a clear of its bit leaves the bit set.
- R4: In line mode, `irq_line` is high exactly when some status bit and its mask bit are both 1. The DMA mask reads at address 1 and the user mask at address 3. A masked-off event is still recorded in status.
- R5: A rising edge on `usr_irq[k]` sets bit k of the user status register, which reads at address 2. After software clears the bit, a level that is still held high does not set it again.
- R6: In message mode, the clock edge after some mask-enabled status bit becomes pending drives `msi_req` high for exactly one cycle. `irq_line` stays 0 in message mode.
- R7: In message mode, an `msi_ack` clears exactly the bits that the message carried. Events that arrive before the ack stay pending and cause the next message.
- R8: In message mode, after a message that carried user bits, new user events send no message until the user status register (address 2) is written. One cycle after that write, a message carries them.
- R9: In message mode, software writes to a status register clear no bits.
- R10: In line mode `msi_req` stays 0.
- R11: Reads are registered. `reg_rdata` shows the addressed register the cycle after `reg_rd`. Register contents are zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | 1 selects message mode, 0 selects line mode |
| dma_evt | input | DMA_N | DMA event pulses, one bit per source |
| usr_irq | input | USR_N | User interrupt lines, active high, pulse or level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 DMA status, 1 DMA mask, 2 user status, 3 user mask |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, registered |
| irq_line | output | 1 | Level interrupt request in line mode |
| msi_req | output | 1 | One-cycle message request in message mode |
| msi_ack | input | 1 | Core acknowledge that the message was sent |

## Verification
The bench builds the block with its defaults: six DMA sources, four user lines and a 32-bit data bus. With these values every DMA bit position can be walked one at a time and checked against its named event. Write-1-to-clear can be tested with mixed data patterns across the whole status field. The four user lines leave room to hold one line high while a second line pulses, so edge detection and message coalescing are both tested against the same handler write.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int DMA_N = 6,
  parameter int USR_N = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_mode,
  input  logic [DMA_N-1:0] dma_evt,
  input  logic [USR_N-1:0] usr_irq,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_line,
  output logic             msi_req,
  input  logic             msi_ack
);
  localparam logic [1:0] A_DST = 2'd0, A_DMSK = 2'd1, A_UST = 2'd2, A_UMSK = 2'd3;

  logic [DMA_N-1:0] dma_st, dma_msk, dma_snap, dma_clr;
  logic [USR_N-1:0] usr_st, usr_msk, usr_snap, usr_clr, usr_prev, usr_rise;
  logic             usr_armed, waiting, msi_done, fire;

  wire wr_dst  = reg_wr && reg_addr == A_DST;
  wire wr_dmsk = reg_wr && reg_addr == A_DMSK;
  wire wr_ust  = reg_wr && reg_addr == A_UST;
  wire wr_umsk = reg_wr && reg_addr == A_UMSK;

  wire [DMA_N-1:0] dma_pend = dma_st & dma_msk;
  wire [USR_N-1:0] usr_pend = usr_armed ? (usr_st & usr_msk) : '0;

  assign usr_rise = usr_irq & ~usr_prev;
  assign msi_done = waiting && msi_ack;
  assign fire     = msi_mode && !waiting && (|dma_pend || |usr_pend);

  always_comb begin
    dma_clr = '0;
    usr_clr = '0;
    if (msi_done) begin
      dma_clr = dma_snap;
      usr_clr = usr_snap;
    end else if (!msi_mode) begin
      if (wr_dst) dma_clr = reg_wdata[DMA_N-1:0];
      if (wr_ust) usr_clr = reg_wdata[USR_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_st    <= '0;
      usr_st    <= '0;
      dma_msk   <= '0;
      usr_msk   <= '0;
      usr_prev  <= '0;
      dma_snap  <= '0;
      usr_snap  <= '0;
      usr_armed <= 1'b1;
      waiting   <= 1'b0;
      msi_req   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      dma_st   <= (dma_st & ~dma_clr) | dma_evt;
      usr_st   <= (usr_st & ~usr_clr) | usr_rise;
      usr_prev <= usr_irq;
      if (wr_dmsk) dma_msk <= reg_wdata[DMA_N-1:0];
      if (wr_umsk) usr_msk <= reg_wdata[USR_N-1:0];

      if (!msi_mode)                   usr_armed <= 1'b1;
      else if (msi_done && |usr_snap)  usr_armed <= 1'b0;
      else if (wr_ust)                 usr_armed <= 1'b1;

      if (!msi_mode)     waiting <= 1'b0;
      else if (fire)     waiting <= 1'b1;
      else if (msi_ack)  waiting <= 1'b0;

      if (fire) begin
        dma_snap <= dma_pend;
        usr_snap <= usr_pend;
      end
      msi_req <= fire;

      if (reg_rd) begin
        case (reg_addr)
          A_DST:   reg_rdata <= {{(DW-DMA_N){1'b0}}, dma_st};
          A_DMSK:  reg_rdata <= {{(DW-DMA_N){1'b0}}, dma_msk};
          A_UST:   reg_rdata <= {{(DW-USR_N){1'b0}}, usr_st};
          default: reg_rdata <= {{(DW-USR_N){1'b0}}, usr_msk};
        endcase
      end
    end
  end

  assign irq_line = !msi_mode && (|(dma_st & dma_msk) || |(usr_st & usr_msk));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_mode && !wr_dst) |=> ((dma_st & $past(dma_st)) == $past(dma_st)));

  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line && !reg_wr) |=> (msi_mode || irq_line));

  assert_user_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((usr_st & ~$past(usr_st) & ~($past(usr_irq) & ~$past(usr_prev))) == '0));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && msi_ack && dma_evt == '0) |=> ((dma_st & $past(dma_snap)) == '0));

  assert_no_msg_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_mode && !$past(msi_mode)) |-> !msi_req);
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic        clk = 0, rst_n = 0, msi_mode = 0;
  logic [5:0]  dma_evt = '0;
  logic [3:0]  usr_irq = '0;
  logic        reg_wr = 0, reg_rd = 0, msi_ack = 0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_line, msi_req;
  int total = 0, bad = 0;
  bit finished = 0;

  irq_status_ctrl uut (.clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .dma_evt(dma_evt),
    .usr_irq(usr_irq), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line),
    .msi_req(msi_req), .msi_ack(msi_ack));

  always #4 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; tick(); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic dma_pulse(input logic [5:0] v);
    dma_evt = v; tick(); dma_evt = '0;
  endtask

  task automatic ack();
    msi_ack = 1; tick(); msi_ack = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d, 0, $sformatf("R1 reset reg %0d", a));
    end
    check(irq_line, 0, "R1 reset irq_line");
    check(msi_req, 0, "R1 reset msi_req");
  endtask

  task automatic t_dma_order();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      dma_pulse(6'(1 << i));
      rd(2'd0, d);
      check(d, 32'(1 << i), $sformatf("R2 dma bit %0d", i));
      check(irq_line, 0, "R4 masked-off event no line");
      wr(2'd0, 32'h3F);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    dma_pulse(6'h3F);
    wr(2'd0, 32'h05);
    rd(2'd0, d); check(d, 32'h3A, "R3 clear pattern 05");
    wr(2'd0, 32'h0);
    rd(2'd0, d); check(d, 32'h3A, "R3 write zero keeps");
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h02; dma_evt = 6'h02;
    tick(); reg_wr = 0; dma_evt = '0;
    rd(2'd0, d); check(d, 32'h3A, "R3 event beats clear");
    wr(2'd0, 32'h3F);
    rd(2'd0, d); check(d, 0, "R3 clear all");
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd1, 32'h10);
    rd(2'd1, d); check(d, 32'h10, "R4/R11 dma mask readback");
    dma_pulse(6'h01);
    check(irq_line, 0, "R4 unmasked source no line");
    dma_pulse(6'h10);
    check(irq_line, 1, "R4 masked source raises line");
    wr(2'd0, 32'h10);
    check(irq_line, 0, "R4 line drops after clear");
    wr(2'd0, 32'h01);
    wr(2'd3, 32'h4);
    rd(2'd3, d); check(d, 32'h4, "R11 user mask readback");
    usr_irq[2] = 1; tick(); usr_irq[2] = 0; tick();
    check(irq_line, 1, "R4 user masked line");
    repeat (3) tick();
    check(irq_line, 1, "R10 line level, no message");
    check(msi_req, 0, "R10 no msi in line mode");
    wr(2'd2, 32'h4);
    check(irq_line, 0, "R4 user line cleared");
    wr(2'd1, 32'h0); wr(2'd3, 32'h0);
  endtask

  task automatic t_user_edge();
    logic [31:0] d;
    usr_irq[1] = 1; tick(); tick();
    rd(2'd2, d); check(d, 32'h2, "R5 level sets bit");
    wr(2'd2, 32'h2);
    repeat (4) tick();
    rd(2'd2, d); check(d, 0, "R5 held level no re-set");
    usr_irq[1] = 0; tick();
    usr_irq[1] = 1; tick(); usr_irq[1] = 0; tick();
    rd(2'd2, d); check(d, 32'h2, "R5 new edge sets bit");
    wr(2'd2, 32'h2);
  endtask

  task automatic t_msi_basic();
    logic [31:0] d;
    msi_mode = 1; wr(2'd1, 32'h3F);
    dma_pulse(6'h04);
    check(msi_req, 0, "R6 no req same edge");
    tick();
    check(msi_req, 1, "R6 req asserted");
    check(irq_line, 0, "R6 no line in message mode");
    dma_pulse(6'h08);
    check(msi_req, 0, "R6 req one cycle");
    ack();
    rd(2'd0, d); check(d, 32'h08, "R7 sent cleared, later held");
    check(msi_req, 1, "R7 next message for held bit");
    tick();
    ack();
    rd(2'd0, d); check(d, 0, "R7 second ack clears");
    wr(2'd1, 32'h0);
  endtask

  task automatic t_msi_user();
    logic [31:0] d;
    int seen;
    wr(2'd3, 32'hF);
    usr_irq[0] = 1; tick(); usr_irq[0] = 0; tick();
    check(msi_req, 1, "R8 first user message");
    tick(); ack();
    usr_irq[1] = 1; tick(); usr_irq[1] = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin tick(); if (msi_req) seen++; end
    check(seen, 0, "R8 coalesced, no message before handler");
    rd(2'd2, d); check(d, 32'h2, "R8 event recorded");
    wr(2'd2, 32'h0);
    check(msi_req, 0, "R8 no req at rearm edge");
    tick();
    check(msi_req, 1, "R8 message after handler write");
    tick(); ack();
    rd(2'd2, d); check(d, 0, "R8 user bits self-cleared");
    wr(2'd3, 32'h0);
  endtask

  task automatic t_msi_nowc();
    logic [31:0] d;
    int seen = 0;
    dma_pulse(6'h20);
    wr(2'd0, 32'h20);
    rd(2'd0, d); check(d, 32'h20, "R9 write does not clear in message mode");
    for (int i = 0; i < 4; i++) begin tick(); if (msi_req) seen++; end
    check(seen, 0, "R6 masked-off no message");
    msi_mode = 0; tick();
    wr(2'd0, 32'h20);
    rd(2'd0, d); check(d, 0, "R3 clear after back to line");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_dma_order();
    t_w1c();
    t_mask();
    t_user_edge();
    t_msi_basic();
    t_msi_user();
    t_msi_nowc();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule